// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the interlock and bypass control for a five-stage in-order integer pipeline with the stages fetch, decode, execute, memory access and write-back. Each cycle it looks at the source register numbers of the instruction in decode, the destination and flags of the instruction in execute, the source numbers of the instruction in execute, and the destination of the instruction in write-back. From these it produces the enables for the program counter and the fetch/decode register, a bubble request for the decode/execute register, and one bypass select for each execute operand.

The only bypass path runs from the write-back latch to the execute operands. A result that is one instruction ahead of its consumer cannot be bypassed, so the consumer waits one cycle in decode. The register file is written before it is read within a cycle, so a consumer three instructions behind its producer reads the new value directly. Branches are not predicted. While a branch is in decode, and again while it resolves in execute, nothing new is fetched and fetch/decode takes a bubble. In the resolving cycle the program counter loads the resolved address, so fetching resumes on the following cycle.

Top module: `hzd_ctrl`

## Requirements
- R1: When the decode instruction uses a source (`id_use_rsN`=1) whose nonzero number equals `ex_rd`, and execute has `ex_wen`=1 or `ex_load`=1, the outputs are `idex_bubble`=1, `ifid_en`=0 and `pc_en`=0. This holds unless `br_resolve`=1.
- R2: A decode source that matches only the write-back destination (`wb_rd`, `wb_wen`=1) causes no stall. With no branch activity, the outputs are `pc_en`=1, `ifid_en`=1, `idex_bubble`=0 and `ifid_bubble`=0.
- R3: Register number 0 never causes a stall and never selects the bypass, even when it matches with its write or load flag set.
- R4: `fwd_a` (or `fwd_b`) is 1 when `wb_wen`=1, `wb_rd` is nonzero and `wb_rd` equals `ex_rs1` (or `ex_rs2`). Otherwise it is 0, which selects the register-file value. The two operands are decided independently.
- R5: A load in execute that feeds a decode source causes exactly one stall cycle. Once the load has moved past execute, the consumer proceeds, and when it reaches execute with the load in write-back, its operand select is 1.
- R6: While `id_is_branch`=1 with no data hazard and `br_resolve`=0, the outputs are `pc_en`=0, `ifid_en`=1, `ifid_bubble`=1 and `idex_bubble`=0.
- R7: On the cycle after a branch leaves decode without a stall, `br_resolve`=1, `pc_en`=1 and `ifid_bubble`=1. On the cycle after that, with no branch in decode, `br_resolve`=0 and fetch runs normally.
- R8: A branch in decode that also meets the R1 condition is held there: `pc_en`=0, `ifid_en`=0, `idex_bubble`=1, `ifid_bubble`=0. `br_resolve` stays 0 on the next cycle.
- R9: During and directly after reset, `br_resolve`=0.
- R10: While `br_resolve`=1, `pc_en`=1, `ifid_en`=1 and `ifid_bubble`=1 hold even if the R1 condition is present. `idex_bubble` still follows the R1 condition.
- R11: A source whose use flag is 0 never causes a stall, even if its number matches `ex_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | AW | First source number of decode instruction |
| id_rs2 | input | AW | Second source number of decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads first source |
| id_use_rs2 | input | 1 | Decode instruction reads second source |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| ex_rd | input | AW | Destination number of execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a memory read |
| ex_rs1 | input | AW | First source number of execute instruction |
| ex_rs2 | input | AW | Second source number of execute instruction |
| wb_rd | input | AW | Destination number in write-back latch |
| wb_wen | input | 1 | Write-back latch writes a register |
| pc_en | output | 1 | Program counter update enable |
| ifid_en | output | 1 | Fetch/decode register load enable |
| ifid_bubble | output | 1 | Fetch/decode loads a no-op instead of a fetched word |
| idex_bubble | output | 1 | Decode/execute loads all-zero control |
| br_resolve | output | 1 | Branch resolving in execute; PC takes resolved address |
| fwd_a | output | 1 | First operand select: 1 = write-back data, 0 = register file |
| fwd_b | output | 1 | Second operand select: 1 = write-back data, 0 = register file |

## Verification
The bench targets back-to-back dependences in both operand positions, register-0 destinations, unused sources that happen to match, and load-use pairs followed across the stall cycle. A design with an extra bypass, or one that ignored the write-back-then-read rule, would stall where none is needed or fail to select the bypass. A design missing the zero-register guard would stall on writes to register 0. The bench also drives branches both with and without a data hazard and overlaps a hazard with the resolve cycle. A broken branch hold would either fetch during the branch shadow, miss the resolving cycle, or lose the branch while it is held.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic {
    FWD_RF = 1'b0,
    FWD_WB = 1'b1
  } fwd_sel_e;

  typedef struct packed {
    logic pc_en;
    logic ifid_en;
    logic ifid_bubble;
    logic idex_bubble;
  } pipe_ctl_t;
endpackage

// File: rtl/hzd_stall_det.sv
module hzd_stall_det #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] src,
  input  logic [NSRC-1:0]         src_use,
  input  logic [AW-1:0]           ex_rd,
  input  logic                    ex_wen,
  input  logic                    ex_load,
  output logic                    hazard
);
  logic            ex_producer;
  logic [NSRC-1:0] hit;

  // A load always writes; either flag marks a pending result without bypass
  assign ex_producer = (ex_wen | ex_load) & (ex_rd != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = ex_producer & src_use[g] & (src[g] == ex_rd);
  end

  assign hazard = |hit;
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] ex_src,
  input  logic [AW-1:0]           wb_rd,
  input  logic                    wb_wen,
  output fwd_sel_e [NSRC-1:0]     sel
);
  logic wb_live;

  assign wb_live = wb_wen & (wb_rd != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    always_comb begin
      sel[g] = FWD_RF;
      if (wb_live && (ex_src[g] == wb_rd)) sel[g] = FWD_WB;
    end
  end
endmodule

// File: rtl/hzd_br_hold.sv
module hzd_br_hold
  import hzd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      id_is_branch,
  input  logic      hazard,
  output logic      br_resolve,
  output pipe_ctl_t ctl
);
  logic br_ex_d;
  logic br_ex_q;

  // Branch moves to execute only when decode is not held
  always_comb begin
    br_ex_d = id_is_branch & ~hazard;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) br_ex_q <= 1'b0;
    else        br_ex_q <= br_ex_d;
  end

  // Resolving branch wins the PC and fetch/decode; data stall keeps ID/EX
  always_comb begin
    ctl.idex_bubble = hazard;
    if (br_ex_q) begin
      ctl.pc_en       = 1'b1;
      ctl.ifid_en     = 1'b1;
      ctl.ifid_bubble = 1'b1;
    end else if (hazard) begin
      ctl.pc_en       = 1'b0;
      ctl.ifid_en     = 1'b0;
      ctl.ifid_bubble = 1'b0;
    end else if (id_is_branch) begin
      ctl.pc_en       = 1'b0;
      ctl.ifid_en     = 1'b1;
      ctl.ifid_bubble = 1'b1;
    end else begin
      ctl.pc_en       = 1'b1;
      ctl.ifid_en     = 1'b1;
      ctl.ifid_bubble = 1'b0;
    end
  end

  assign br_resolve = br_ex_q;
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic          id_is_branch,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic          pc_en,
  output logic          ifid_en,
  output logic          ifid_bubble,
  output logic          idex_bubble,
  output logic          br_resolve,
  output logic          fwd_a,
  output logic          fwd_b
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] id_src;
  logic [NSRC-1:0]         id_use;
  logic [NSRC-1:0][AW-1:0] ex_src;
  fwd_sel_e [NSRC-1:0]     sel;
  logic                    hazard;
  pipe_ctl_t               ctl;

  assign id_src = {id_rs2, id_rs1};
  assign id_use = {id_use_rs2, id_use_rs1};
  assign ex_src = {ex_rs2, ex_rs1};

  hzd_stall_det #(.AW(AW), .NSRC(NSRC)) u_stall (
    .src    (id_src),
    .src_use(id_use),
    .ex_rd  (ex_rd),
    .ex_wen (ex_wen),
    .ex_load(ex_load),
    .hazard (hazard)
  );

  hzd_fwd_unit #(.AW(AW), .NSRC(NSRC)) u_fwd (
    .ex_src(ex_src),
    .wb_rd (wb_rd),
    .wb_wen(wb_wen),
    .sel   (sel)
  );

  hzd_br_hold u_br (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_is_branch(id_is_branch),
    .hazard      (hazard),
    .br_resolve  (br_resolve),
    .ctl         (ctl)
  );

  assign pc_en       = ctl.pc_en;
  assign ifid_en     = ctl.ifid_en;
  assign ifid_bubble = ctl.ifid_bubble;
  assign idex_bubble = ctl.idex_bubble;
  assign fwd_a       = (sel[0] == FWD_WB);
  assign fwd_b       = (sel[1] == FWD_WB);
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic          id_use_rs1,
  input logic          id_use_rs2,
  input logic          id_is_branch,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] wb_rd,
  input logic          wb_wen,
  input logic          pc_en,
  input logic          ifid_en,
  input logic          ifid_bubble,
  input logic          idex_bubble,
  input logic          br_resolve,
  input logic          fwd_a
);
  logic raw1;
  assign raw1 = (ex_wen | ex_load) && ex_rd != '0 &&
                ((id_use_rs1 && id_rs1 == ex_rd) || (id_use_rs2 && id_rs2 == ex_rd));

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (raw1 && !br_resolve) |-> (idex_bubble && !ifid_en && !pc_en));

  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !idex_bubble);

  p_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && wb_rd != '0 && wb_rd == ex_rs1) |-> fwd_a);

  p_nofwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_wen |-> !fwd_a);

  p_brid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_branch && !br_resolve) |-> !pc_en);

  p_resolve_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_branch && !idex_bubble) |=> br_resolve);

  p_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_branch && idex_bubble) |=> !br_resolve);

  p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    br_resolve |-> (pc_en && ifid_en && ifid_bubble));

  p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_use_rs1 && !id_use_rs2) |-> !idex_bubble);
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
  .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .id_is_branch(id_is_branch),
  .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load), .ex_rs1(ex_rs1),
  .wb_rd(wb_rd), .wb_wen(wb_wen), .pc_en(pc_en), .ifid_en(ifid_en),
  .ifid_bubble(ifid_bubble), .idex_bubble(idex_bubble), .br_resolve(br_resolve),
  .fwd_a(fwd_a)
);

// File: tb/sim_hzd_ctrl.sv
module sim_hzd_ctrl;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] id_rs1, id_rs2, ex_rd, ex_rs1, ex_rs2, wb_rd;
  logic id_use_rs1, id_use_rs2, id_is_branch, ex_wen, ex_load, wb_wen;
  logic pc_en, ifid_en, ifid_bubble, idex_bubble, br_resolve, fwd_a, fwd_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hzd_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .id_is_branch(id_is_branch),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load), .ex_rs1(ex_rs1),
    .ex_rs2(ex_rs2), .wb_rd(wb_rd), .wb_wen(wb_wen), .pc_en(pc_en),
    .ifid_en(ifid_en), .ifid_bubble(ifid_bubble), .idex_bubble(idex_bubble),
    .br_resolve(br_resolve), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // packed view {pc_en, ifid_en, ifid_bubble, idex_bubble, br_resolve}
  function automatic logic [4:0] ctl();
    return {pc_en, ifid_en, ifid_bubble, idex_bubble, br_resolve};
  endfunction

  task automatic idle();
    id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 0; id_use_rs2 = 0; id_is_branch = 0;
    ex_rd = '0; ex_wen = 0; ex_load = 0; ex_rs1 = '0; ex_rs2 = '0;
    wb_rd = '0; wb_wen = 0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    idle();
    rst_n = 1'b0;
    #1;
    check("R9 reset", ctl(), 5'b11000);
    step(); step();
    rst_n = 1'b1;
    step();
    check("R9 after release", ctl(), 5'b11000);
  endtask

  task automatic t_alu_raw();
    idle();
    id_rs1 = 5'd7; id_use_rs1 = 1; ex_rd = 5'd7; ex_wen = 1; #1;
    check("R1 rs1 raw", ctl(), 5'b00010);
    idle();
    id_rs2 = 5'd12; id_use_rs2 = 1; ex_rd = 5'd12; ex_wen = 1; #1;
    check("R1 rs2 raw", ctl(), 5'b00010);
    idle();
    id_rs1 = 5'd3; id_use_rs1 = 1; ex_rd = 5'd4; ex_wen = 1; #1;
    check("R1 no match", ctl(), 5'b11000);
  endtask

  task automatic t_wb_no_stall();
    idle();
    id_rs1 = 5'd9; id_use_rs1 = 1; wb_rd = 5'd9; wb_wen = 1; #1;
    check("R2 wb match no stall", ctl(), 5'b11000);
    idle();
    id_rs1 = 5'd9; id_use_rs1 = 1; ex_rd = 5'd9; ex_wen = 0; #1;
    check("R2 non-writing ex", ctl(), 5'b11000);
  endtask

  task automatic t_zero();
    idle();
    id_use_rs1 = 1; id_use_rs2 = 1; ex_wen = 1; ex_load = 1; #1;
    check("R3 zero no stall", ctl(), 5'b11000);
    wb_wen = 1; #1;
    check("R3 zero no fwd", {3'b0, fwd_a, fwd_b}, 5'b00000);
  endtask

  task automatic t_fwd();
    idle();
    wb_wen = 1; wb_rd = 5'd5; ex_rs1 = 5'd5; ex_rs2 = 5'd6; #1;
    check("R4 fwd a only", {3'b0, fwd_a, fwd_b}, 5'b00010);
    ex_rs1 = 5'd1; ex_rs2 = 5'd5; #1;
    check("R4 fwd b only", {3'b0, fwd_a, fwd_b}, 5'b00001);
    ex_rs1 = 5'd5; #1;
    check("R4 fwd both", {3'b0, fwd_a, fwd_b}, 5'b00011);
    wb_wen = 0; #1;
    check("R4 no write no fwd", {3'b0, fwd_a, fwd_b}, 5'b00000);
  endtask

  task automatic t_load_use();
    idle();
    id_rs1 = 5'd8; id_use_rs1 = 1; ex_rd = 5'd8; ex_load = 1; #1;
    check("R5 load-use stall", ctl(), 5'b00010);
    step();
    // load now past EX (bubble in EX), consumer still in ID
    idle();
    id_rs1 = 5'd8; id_use_rs1 = 1; #1;
    check("R5 one stall only", ctl(), 5'b11000);
    step();
    // consumer in EX, load in WB
    idle();
    ex_rs1 = 5'd8; wb_rd = 5'd8; wb_wen = 1; #1;
    check("R5 forwarded", {3'b0, fwd_a, fwd_b}, 5'b00010);
  endtask

  task automatic t_branch();
    idle();
    id_is_branch = 1; #1;
    check("R6 branch in ID", ctl(), 5'b01100);
    step();
    idle(); #1;
    check("R7 resolve cycle", ctl(), 5'b11101);
    step();
    check("R7 fetch resumes", ctl(), 5'b11000);
  endtask

  task automatic t_branch_held();
    idle();
    id_is_branch = 1; id_rs1 = 5'd2; id_use_rs1 = 1; ex_rd = 5'd2; ex_wen = 1; #1;
    check("R8 branch held", ctl(), 5'b00010);
    step();
    ex_wen = 0; #1;
    check("R8 no resolve after hold", ctl(), 5'b01100);
    step();
    idle(); #1;
    check("R7 resolve after held", ctl(), 5'b11101);
    step();
  endtask

  task automatic t_prio();
    idle();
    id_is_branch = 1; #1;
    step();
    idle();
    id_rs1 = 5'd11; id_use_rs1 = 1; ex_rd = 5'd11; ex_wen = 1; #1;
    check("R10 resolve beats stall", ctl(), 5'b11111);
    step();
    idle(); #1;
    check("R10 back to normal", ctl(), 5'b11000);
  endtask

  task automatic t_unused();
    idle();
    id_rs1 = 5'd14; id_rs2 = 5'd14; ex_rd = 5'd14; ex_wen = 1; ex_load = 1; #1;
    check("R11 unused sources", ctl(), 5'b11000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_alu_raw();
        t_wb_no_stall();
        t_zero();
        t_fwd();
        t_load_use();
        t_branch();
        t_branch_held();
        t_prio();
        t_unused();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule